// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Register Bank

This block holds one 32-bit control and status word for each channel of a multi-channel DMA controller. Software writes a channel's word to start or stop the channel, to set the interrupt enables and to clear event flags. The transfer engine reports events to the block as single-cycle pulses per channel, and a level per channel shows that the channel's peripheral request is active. Each word mixes three kinds of bit: sticky event flags that software clears by writing a one, control bits that take the written value directly, and command bits that act on the compare flag without being stored.

From each word the block derives one interrupt bit per channel. The start and end flags always count. The stopped, end-of-receive and request-after-stop flags count only while their own enable bit is set. The per-channel bits form a summary vector that can be read back, and a single interrupt line is high while any summary bit is set. Reads are combinational: the read port returns the selected channel's word, or the summary when the summary select is high. Writes take effect at the next clock edge. There is no data stream at this block's edge, so every pin is a plain level or pulse.

Top module: `chanstat_regs`

## Requirements
- R1: After reset every channel word reads 0x00000008 (only the stopped flag, bit 3, set), the summary is zero and the interrupt line is low.
- R2: A write with a one in bit 0 (bus error), bit 1 (start), bit 2 (end) or bit 9 (end-of-receive) clears that flag. A zero in those positions leaves the flag as it was. Flags in bits 3, 4 and 10 are not cleared by the write pattern.
- R3: Bits 31..26 and bit 23 of a write are stored as written, whether one or zero. Bit 31 is run, 30 no-descriptor-fetch, 29 stop interrupt enable, 28 end-of-receive interrupt enable, 27 end-of-receive jump enable, 26 end-of-receive stop enable, 23 request-after-stop interrupt enable. Bits 22, 21..11 and 7..5 always read zero.
- R4: Write bit 24 clears the compare flag (bit 10) and write bit 25 sets it. When both are one, the flag ends set. Bits 24 and 25 always read zero.
- R5: A write with bit 31 set clears the stopped flag. A write with neither bit 31 nor bit 22 (mask-run) set sets the stopped flag. A write with only bit 22 of the two set leaves the stopped flag unchanged.
- R6: Read bit 8 equals the selected channel's request-active input in the same cycle. It is not stored.
- R7: A channel's interrupt bit is start OR end OR (stopped AND bit 29) OR (end-of-receive AND bit 28) OR (request-after-stop AND bit 23).
- R8: The summary output holds one interrupt bit per channel, at bit index equal to the channel number. A read with the summary select high returns it zero-extended. The interrupt line is the OR of the summary.
- R9: An event pulse sets its flag at the next edge: bus error bit 0, start bit 1, end bit 2, request-after-stop bit 4, end-of-receive bit 9. A stop pulse sets bit 3 and clears run. An event wins over a same-cycle write that would clear its flag or set run.
- R10: A write whose channel index is at or above the channel count changes no channel.
- R11: The run output of each channel equals bit 31 of its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_ch | input | 5 | Channel index of the write |
| wr_data | input | 32 | Write value |
| rd_sum | input | 1 | Read the summary instead of a channel word |
| rd_ch | input | 5 | Channel index of the read |
| rd_data | output | 32 | Read value, combinational |
| req_active | input | NUM_CH | Peripheral request active, per channel |
| evt_buserr | input | NUM_CH | Bus error pulse, per channel |
| evt_start | input | NUM_CH | Descriptor start pulse, per channel |
| evt_end | input | NUM_CH | Transfer end pulse, per channel |
| evt_stop | input | NUM_CH | Channel stopped pulse, per channel |
| evt_eor | input | NUM_CH | End-of-receive pulse, per channel |
| evt_ras | input | NUM_CH | Request-after-stop pulse, per channel |
| chan_run | output | NUM_CH | Run bit of each channel |
| int_vec | output | NUM_CH | Per-channel interrupt summary |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench targets write patterns that combine several bit kinds in one word. One is an all-ones write: a design that stored bits 24/25 or let bit 22 through would read those bits back as one. Another is a mask-run-only write: a design that treated mask-run like a stop would set the stopped flag. It also drives an event in the same cycle as a write that clears that event's flag, and a stop pulse together with a run write. A design with the wrong priority would lose a sticky flag or leave a stopped channel running. Gated flags are checked with their enables on and off, because a design that ignored an enable would raise or drop the interrupt line at the wrong time. A write to an index past the channel count, and the request level's effect on read bit 8, are both checked at the read port.

// File: rtl/chanstat_pkg.sv
package chanstat_pkg;
  localparam int B_BUSERR  = 0;
  localparam int B_START   = 1;
  localparam int B_END     = 2;
  localparam int B_STOPPED = 3;
  localparam int B_RAS     = 4;
  localparam int B_REQ     = 8;
  localparam int B_EOR     = 9;
  localparam int B_CMP     = 10;
  localparam int B_MASKRUN = 22;
  localparam int B_RASEN   = 23;
  localparam int B_CMPCLR  = 24;
  localparam int B_CMPSET  = 25;
  localparam int B_EORSTOP = 26;
  localparam int B_EORJMP  = 27;
  localparam int B_EOREN   = 28;
  localparam int B_STOPEN  = 29;
  localparam int B_NODESC  = 30;
  localparam int B_RUN     = 31;

  localparam logic [31:0] KEEP_MASK = 32'h0000_071F;
  localparam logic [31:0] W1C_MASK  = 32'h0000_0207;
  localparam logic [31:0] CTRL_MASK = 32'hFC80_0000;
  localparam logic [31:0] RST_WORD  = 32'h0000_0008;

  function automatic logic word_irq(input logic [31:0] w);
    return w[B_START] | w[B_END]
         | (w[B_STOPPED] & w[B_STOPEN])
         | (w[B_EOR] & w[B_EOREN])
         | (w[B_RAS] & w[B_RASEN]);
  endfunction
endpackage

// File: rtl/chanstat_cell.sv
module chanstat_cell
  import chanstat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wd,
  input  logic        ev_buserr,
  input  logic        ev_start,
  input  logic        ev_end,
  input  logic        ev_stop,
  input  logic        ev_eor,
  input  logic        ev_ras,
  output logic [31:0] word_q,
  output logic        int_bit
);
  logic [31:0] nxt;

  always_comb begin
    nxt = word_q;
    if (we) begin
      nxt = (word_q & KEEP_MASK & ~(wd & W1C_MASK)) | (wd & CTRL_MASK);
      if (wd[B_RUN])          nxt[B_STOPPED] = 1'b0;
      else if (!wd[B_MASKRUN]) nxt[B_STOPPED] = 1'b1;
      if (wd[B_CMPCLR])       nxt[B_CMP] = 1'b0;
      if (wd[B_CMPSET])       nxt[B_CMP] = 1'b1;
    end
    if (ev_buserr) nxt[B_BUSERR] = 1'b1;
    if (ev_start)  nxt[B_START]  = 1'b1;
    if (ev_end)    nxt[B_END]    = 1'b1;
    if (ev_eor)    nxt[B_EOR]    = 1'b1;
    if (ev_ras)    nxt[B_RAS]    = 1'b1;
    if (ev_stop) begin
      nxt[B_STOPPED] = 1'b1;
      nxt[B_RUN]     = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= RST_WORD;
    else        word_q <= nxt;
  end

  assign int_bit = word_irq(word_q);
endmodule

// File: rtl/chanstat_rdmux.sv
module chanstat_rdmux
  import chanstat_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = 5
) (
  input  logic [NUM_CH-1:0][31:0] words,
  input  logic [NUM_CH-1:0]       req_active,
  input  logic [NUM_CH-1:0]       int_vec,
  input  logic                    rd_sum,
  input  logic [IDX_W-1:0]        rd_ch,
  output logic [31:0]             rd_data
);
  logic [31:0] sel_word;
  logic [31:0] sum_word;

  always_comb begin
    sel_word = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_ch == IDX_W'(c)) begin
        sel_word = words[c];
        sel_word[B_REQ] = req_active[c];
      end
    end
    sum_word = '0;
    sum_word[NUM_CH-1:0] = int_vec;
  end

  assign rd_data = rd_sum ? sum_word : sel_word;
endmodule

// File: rtl/chanstat_regs.sv
module chanstat_regs
  import chanstat_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [4:0]        wr_ch,
  input  logic [31:0]       wr_data,
  input  logic              rd_sum,
  input  logic [4:0]        rd_ch,
  output logic [31:0]       rd_data,
  input  logic [NUM_CH-1:0] req_active,
  input  logic [NUM_CH-1:0] evt_buserr,
  input  logic [NUM_CH-1:0] evt_start,
  input  logic [NUM_CH-1:0] evt_end,
  input  logic [NUM_CH-1:0] evt_stop,
  input  logic [NUM_CH-1:0] evt_eor,
  input  logic [NUM_CH-1:0] evt_ras,
  output logic [NUM_CH-1:0] chan_run,
  output logic [NUM_CH-1:0] int_vec,
  output logic              irq
);
  localparam int IDX_W = 5;

  logic [NUM_CH-1:0][31:0] stat_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chanstat_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (wr_en && (wr_ch == IDX_W'(c))),
      .wd        (wr_data),
      .ev_buserr (evt_buserr[c]),
      .ev_start  (evt_start[c]),
      .ev_end    (evt_end[c]),
      .ev_stop   (evt_stop[c]),
      .ev_eor    (evt_eor[c]),
      .ev_ras    (evt_ras[c]),
      .word_q    (stat_q[c]),
      .int_bit   (int_vec[c])
    );
    assign chan_run[c] = stat_q[c][B_RUN];
  end

  assign irq = |int_vec;

  chanstat_rdmux #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_rdmux (
    .words      (stat_q),
    .req_active (req_active),
    .int_vec    (int_vec),
    .rd_sum     (rd_sum),
    .rd_ch      (rd_ch),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/chanstat_regs_chk.sv
module chanstat_regs_chk #(
  parameter int NUM_CH = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [4:0]              wr_ch,
  input logic [31:0]             wr_data,
  input logic [NUM_CH-1:0]       evt_start,
  input logic [NUM_CH-1:0]       evt_stop,
  input logic [NUM_CH-1:0][31:0] stat_q,
  input logic [NUM_CH-1:0]       int_vec,
  input logic [NUM_CH-1:0]       chan_run,
  input logic                    irq
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    assert_run_clears_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ch == 5'(c) && wr_data[31] && !evt_stop[c]) |=> !stat_q[c][3]);

    assert_idle_sets_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ch == 5'(c) && !wr_data[31] && !wr_data[22]) |=> stat_q[c][3]);

    assert_cmp_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ch == 5'(c) && wr_data[25]) |=> (stat_q[c][10] && !stat_q[c][25] && !stat_q[c][24]));

    assert_ctrl_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ch == 5'(c) && !evt_stop[c]) |=>
        (stat_q[c][31:26] == $past(wr_data[31:26]) && stat_q[c][23] == $past(wr_data[23])));

    assert_start_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_start[c] |=> stat_q[c][1]);

    assert_stop_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_stop[c] |=> (!chan_run[c] && stat_q[c][3]));

    assert_start_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[c][1] |-> (int_vec[c] && irq));
  end
endmodule

bind chanstat_regs chanstat_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_ch     (wr_ch),
  .wr_data   (wr_data),
  .evt_start (evt_start),
  .evt_stop  (evt_stop),
  .stat_q    (stat_q),
  .int_vec   (int_vec),
  .chan_run  (chan_run),
  .irq       (irq)
);

// File: tb/chanstat_regs_tb.sv
module chanstat_regs_tb;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [4:0]    wr_ch = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_sum = 1'b0;
  logic [4:0]    rd_ch = '0;
  logic [31:0]   rd_data;
  logic [N-1:0]  req_active = '0;
  logic [N-1:0]  evt_buserr = '0, evt_start = '0, evt_end = '0;
  logic [N-1:0]  evt_stop = '0, evt_eor = '0, evt_ras = '0;
  logic [N-1:0]  chan_run, int_vec;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  chanstat_regs #(.NUM_CH(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_sum(rd_sum), .rd_ch(rd_ch), .rd_data(rd_data), .req_active(req_active),
    .evt_buserr(evt_buserr), .evt_start(evt_start), .evt_end(evt_end),
    .evt_stop(evt_stop), .evt_eor(evt_eor), .evt_ras(evt_ras),
    .chan_run(chan_run), .int_vec(int_vec), .irq(irq)
  );

  // Behavioural reference, one word per channel, updated at each edge.
  logic [31:0] m_st [N];

  function automatic logic m_irq(input logic [31:0] w);
    return w[1] || w[2] || (w[3] && w[29]) || (w[9] && w[28]) || (w[4] && w[23]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < N; c++) m_st[c] = 32'h8;
    end else begin
      for (int c = 0; c < N; c++) begin
        logic [31:0] w;
        w = m_st[c];
        if (wr_en && wr_ch == 5'(c)) begin
          for (int b = 0; b < 32; b++) begin
            if (b >= 26 || b == 23) w[b] = wr_data[b];
            else if (b == 0 || b == 1 || b == 2 || b == 9) w[b] = w[b] && !wr_data[b];
            else if (b == 3 || b == 4 || b == 10) w[b] = w[b];
            else w[b] = 1'b0;
          end
          if (wr_data[31]) w[3] = 1'b0;
          else if (!wr_data[22]) w[3] = 1'b1;
          if (wr_data[24]) w[10] = 1'b0;
          if (wr_data[25]) w[10] = 1'b1;
        end
        if (evt_buserr[c]) w[0] = 1'b1;
        if (evt_start[c])  w[1] = 1'b1;
        if (evt_end[c])    w[2] = 1'b1;
        if (evt_ras[c])    w[4] = 1'b1;
        if (evt_eor[c])    w[9] = 1'b1;
        if (evt_stop[c]) begin w[3] = 1'b1; w[31] = 1'b0; end
        m_st[c] = w;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input int ch, input string tag, input logic [31:0] exp);
    rd_sum = 1'b0;
    rd_ch  = 5'(ch);
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic wr(input int ch, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 5'(ch); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_evts();
    evt_buserr = '0; evt_start = '0; evt_end = '0;
    evt_stop = '0; evt_eor = '0; evt_ras = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(0, "R1 ch0 reset", 32'h8);
    rd(N-1, "R1 last ch reset", 32'h8);
    chk("R1 summary reset", 32'(int_vec), 32'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);

    wr(1, 32'h8000_0000);
    rd(1, "R5 run clears stopped", 32'h8000_0000);
    chk("R11 run output", 32'(chan_run), 32'h2);

    wr(1, 32'hFFFF_FFFF);
    rd(1, "R3 R4 all-ones write", 32'hFC80_0400);

    wr(1, 32'h0100_0000);
    rd(1, "R4 cmp clear and R5 idle stop", 32'h8);

    wr(1, 32'h0040_0000);
    rd(1, "R5 maskrun keeps stopped set", 32'h8);
    wr(1, 32'h8000_0000);
    wr(1, 32'h0040_0000);
    rd(1, "R5 maskrun keeps stopped clear", 32'h0);
    chk("R11 run output cleared", 32'(chan_run), 32'h0);

    @(negedge clk);
    evt_start[2] = 1'b1; evt_end[2] = 1'b1; evt_eor[2] = 1'b1;
    evt_buserr[2] = 1'b1; evt_ras[2] = 1'b1;
    @(negedge clk);
    clear_evts();
    rd(2, "R9 event flags", 32'h0000_021F);
    chk("R7 start/end count", 32'(int_vec), 32'h4);
    chk("R8 irq high", 32'(irq), 32'h1);

    wr(2, 32'h0000_0006);
    rd(2, "R2 clear start end", 32'h0000_0219);
    chk("R7 gated flags masked", 32'(int_vec), 32'h0);
    chk("R8 irq low", 32'(irq), 32'h0);

    wr(2, 32'h1000_0000);
    chk("R7 eor enable", 32'(int_vec), 32'h4);
    wr(2, 32'h0000_0201);
    rd(2, "R2 clear eor buserr", 32'h0000_0018);
    chk("R7 eor disabled", 32'(int_vec), 32'h0);

    wr(2, 32'h2080_0000);
    rd(2, "R3 stop/ras enables", 32'h2080_0018);
    rd_sum = 1'b1; #1;
    chk("R8 summary read", rd_data, 32'h4);
    rd_sum = 1'b0;

    req_active[3] = 1'b1;
    rd(3, "R6 request pending", 32'h108);
    req_active[3] = 1'b0;
    rd(3, "R6 request dropped", 32'h8);

    @(negedge clk);
    wr_en = 1'b1; wr_ch = 5'd4; wr_data = 32'h0000_0002; evt_start[4] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; clear_evts();
    rd(4, "R9 event beats clear", 32'h0000_000A);

    @(negedge clk);
    wr_en = 1'b1; wr_ch = 5'd5; wr_data = 32'h8000_0000; evt_stop[5] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; clear_evts();
    rd(5, "R9 stop beats run", 32'h8);
    chk("R11 run after stop", 32'(chan_run), 32'h0);

    wr(9, 32'hFFFF_FFFF);
    rd(0, "R10 out-of-range ch0", 32'h8);
    rd(7, "R10 out-of-range ch7", 32'h8);
    chk("R10 run untouched", 32'(chan_run), 32'h0);

    // Random phase against the reference model.
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      #1;
      for (int c = 0; c < N; c++) begin
        logic [31:0] e;
        rd_sum = 1'b0; rd_ch = 5'(c); #1;
        e = m_st[c]; e[8] = req_active[c];
        chk("R6 random word", rd_data, e);
      end
      begin
        logic [N-1:0] ev;
        for (int c = 0; c < N; c++) ev[c] = m_irq(m_st[c]);
        chk("R7 random summary", 32'(int_vec), 32'(ev));
        chk("R8 random irq", 32'(irq), 32'(|ev));
        for (int c = 0; c < N; c++) chk("R11 random run", 32'(chan_run[c]), 32'(m_st[c][31]));
      end
      wr_en      = ($urandom_range(0, 2) == 0);
      wr_ch      = 5'($urandom_range(0, 9));
      wr_data    = $urandom();
      req_active = N'($urandom());
      evt_buserr = N'($urandom() & $urandom() & $urandom());
      evt_start  = N'($urandom() & $urandom() & $urandom());
      evt_end    = N'($urandom() & $urandom() & $urandom());
      evt_stop   = N'($urandom() & $urandom() & $urandom());
      evt_eor    = N'($urandom() & $urandom() & $urandom());
      evt_ras    = N'($urandom() & $urandom() & $urandom());
    end
    @(negedge clk);
    wr_en = 1'b0; clear_evts();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule